// File: doc/BRIEF.md
# Serial Interrupt Message Receiver

This block listens to a two-wire serial interrupt bus. On this bus, one 2-bit symbol is carried per bus cycle. An idle receiver waits for the start symbol. Once the start symbol arrives, the receiver counts the bus cycles of the frame and shifts the field symbols into a register. It keeps a running checksum over those symbols and compares it with the checksum symbol. It then decides whether the local unit is the target, using a physical ID and a logical ID that are supplied as inputs. Physical destinations are matched only on the low four destination bits. Logical destinations are matched on all eight bits.

In the first status cycle the receiver drives the bus. It drives an error symbol if the checksum does not match. It drives a focus-claim symbol if it owns a lowest-priority message. The bus is wired-OR, so after driving, the receiver reads back the combined status. From that status it decides three things: whether the interrupt is delivered locally, whether the frame stays short or grows to the long arbitration format, and when the next frame may begin. The arbitration cycles of a long frame are skipped and not interpreted.

Top module: `irq_msg_rx`

## Requirements
- R1: While no frame is open, the symbol 01 starts a frame and its cycle counts as cycle 1. Any other idle symbol is ignored: it produces no bus drive and no output pulse.
- R2: Cycles 6 to 16 carry, high bit first: {destMode, mode2}, {mode1, mode0}, {level, trigger}, the vector (bits 7:6, 5:4, 3:2, 1:0), then the destination (bits 7:6, 5:4, 3:2, 1:0). The decoded fields and the one-cycle pulses appear in cycle 20 of every frame.
- R3: The checksum is the modulo-4 sum of the eleven symbols of cycles 6 to 16, compared with the cycle-17 symbol. On a mismatch the receiver drives 01 in cycle 19, pulses csumErr and gives no msgValid.
- R4: With destMode 0 (physical), a destination whose bits 3:0 equal physId is accepted, whatever the value of bits 7:4.
- R5: With destMode 0, destination bits 3:0 equal to 1111 are accepted by every receiver.
- R6: With destMode 1 (logical), a frame is accepted when the bitwise AND of the 8-bit destination and logId is nonzero.
- R7: A frame that is not addressed to this unit gives no msgValid and no bus drive.
- R8: With delivery mode 001 (lowest priority), an addressed frame with a good checksum and localFocus high makes the receiver drive 10 in cycle 19. It then pulses msgValid together with focusAccept.
- R9: A lowest-priority frame whose cycle-19 bus status reads 00 is extended to 34 cycles. Symbols in cycles 22 to 34 start no frame. If the frame is addressed and the checksum is good, extendReq pulses and msgValid does not.
- R10: A lowest-priority frame whose cycle-19 status reads 10 because another unit claimed it ends after cycle 21. A receiver that is not the focus unit then gives no msgValid and no extendReq.
- R11: A non-lowest-priority addressed frame with a good checksum pulses msgValid. A 21-cycle frame ends after cycle 21, and a start symbol in the very next cycle opens a new frame.
- R12: During reset all pulse outputs, field outputs and busDrive are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one symbol per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 2 | Wired-OR bus symbol as observed |
| busDrive | output | 2 | Symbol this unit drives onto the bus |
| physId | input | 4 | Local physical ID |
| logId | input | 8 | Local logical ID mask |
| localFocus | input | 1 | Local unit already owns the vector (focus) |
| msgValid | output | 1 | Interrupt accepted, one-cycle pulse |
| csumErr | output | 1 | Checksum mismatch, one-cycle pulse |
| focusAccept | output | 1 | Accepted as focus unit, one-cycle pulse |
| extendReq | output | 1 | Long arbitration frame needed, one-cycle pulse |
| vector | output | 8 | Decoded interrupt vector |
| delivMode | output | 3 | Decoded delivery mode |
| trigMode | output | 1 | Decoded trigger mode |
| level | output | 1 | Decoded level bit |
| destMode | output | 1 | Decoded destination mode |

## Verification
The bench uses the default frame lengths of 21 and 34 cycles. With these lengths, the short path and the extended path can both be reached within a few hundred cycles. Frames are sent back to back, so the exact end cycle of each frame matters: the start symbol placed in cycle 22 is either a new frame or an ignored arbitration symbol. The bench also models the wired-OR bus, so that another unit's status and the receiver's own status merge in cycle 19.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int SYM_W    = 2;
  localparam int VEC_W    = 8;
  localparam int DEST_W   = 8;
  localparam int PHYS_W   = 4;
  localparam int MODE_W   = 3;
  localparam int FIELD_SYMS = 11;
  localparam int SHREG_W  = FIELD_SYMS * SYM_W;

  localparam int CYC_FIELD_FIRST = 6;
  localparam int CYC_FIELD_LAST  = 16;
  localparam int CYC_CSUM        = 17;
  localparam int CYC_STATUS0     = 19;

  localparam logic [SYM_W-1:0] SYM_START = 2'b01;
  localparam logic [SYM_W-1:0] SYM_ERR   = 2'b01;
  localparam logic [SYM_W-1:0] SYM_FOCUS = 2'b10;
  localparam logic [SYM_W-1:0] SYM_NONE  = 2'b00;

  localparam logic [MODE_W-1:0] MODE_LOWPRIO = 3'b001;

  typedef struct packed {
    logic frameStart;
    logic shiftEn;
    logic csumCheck;
    logic statusCyc;
  } ctl_t;
endpackage

// File: rtl/irx_ctrl.sv
module irx_ctrl
  import irx_pkg::*;
#(
  parameter int SHORT_LEN = 21,
  parameter int LONG_LEN  = 34,
  localparam int CNT_W    = $clog2(LONG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] busIn,
  input  logic             lowPrio,
  output ctl_t             ctl
);
  logic [CNT_W-1:0] cyc;
  logic             extend;
  logic [CNT_W-1:0] lastCyc;
  logic             inFrame;

  assign inFrame = (cyc != '0);
  assign lastCyc = extend ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);

  always_comb begin
    ctl.frameStart = !inFrame && (busIn == SYM_START);
    ctl.shiftEn    = (cyc >= CNT_W'(CYC_FIELD_FIRST)) && (cyc <= CNT_W'(CYC_FIELD_LAST));
    ctl.csumCheck  = (cyc == CNT_W'(CYC_CSUM));
    ctl.statusCyc  = (cyc == CNT_W'(CYC_STATUS0));
  end

  // cycle counter: holds the number of the current frame cycle, 0 when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyc <= '0;
    end else if (!inFrame) begin
      if (ctl.frameStart) cyc <= CNT_W'(2);
    end else if (cyc == lastCyc) begin
      cyc <= '0;
    end else begin
      cyc <= cyc + CNT_W'(1);
    end
  end

  // long format chosen when status cycle 0 reads empty on a lowest-priority frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extend <= 1'b0;
    end else if (ctl.frameStart) begin
      extend <= 1'b0;
    end else if (ctl.statusCyc) begin
      extend <= lowPrio && (busIn == SYM_NONE);
    end
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameStart |=> (cyc == CNT_W'(2))); // R1
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!inFrame && busIn != SYM_START) |=> !inFrame); // R1
  AST_SHORT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == CNT_W'(SHORT_LEN) && !extend) |=> !inFrame); // R11
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    cyc <= CNT_W'(LONG_LEN)); // R9
endmodule

// File: rtl/irx_dpath.sv
module irx_dpath
  import irx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [SYM_W-1:0]  busIn,
  input  logic [PHYS_W-1:0] physId,
  input  logic [DEST_W-1:0] logId,
  input  logic              localFocus,
  output logic              lowPrio,
  output logic [SYM_W-1:0]  busDrive,
  output logic              msgValid,
  output logic              csumErr,
  output logic              focusAccept,
  output logic              extendReq,
  output logic [VEC_W-1:0]  vector,
  output logic [MODE_W-1:0] delivMode,
  output logic              trigMode,
  output logic              level,
  output logic              destMode
);
  logic [SHREG_W-1:0] shreg;
  logic [SYM_W-1:0]   sum;
  logic               csumBad;

  logic              dmR, lvlR, trigR;
  logic [MODE_W-1:0] modeR;
  logic [VEC_W-1:0]  vecR;
  logic [DEST_W-1:0] destR;
  logic              physHit, logHit, addressed, claim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      sum     <= '0;
      csumBad <= 1'b0;
    end else begin
      if (ctl.frameStart) begin
        sum <= '0;
      end else if (ctl.shiftEn) begin
        shreg <= {shreg[SHREG_W-SYM_W-1:0], busIn};
        sum   <= sum + busIn;
      end
      if (ctl.csumCheck) csumBad <= (busIn != sum);
    end
  end

  // field positions after the last destination symbol has shifted in
  assign dmR   = shreg[SHREG_W-1];
  assign modeR = shreg[SHREG_W-2 -: MODE_W];
  assign lvlR  = shreg[SHREG_W-2-MODE_W];
  assign trigR = shreg[SHREG_W-3-MODE_W];
  assign vecR  = shreg[DEST_W+VEC_W-1 -: VEC_W];
  assign destR = shreg[DEST_W-1:0];

  assign physHit   = (destR[PHYS_W-1:0] == physId) || (&destR[PHYS_W-1:0]);
  assign logHit    = |(destR & logId);
  assign addressed = dmR ? logHit : physHit;
  assign lowPrio   = (modeR == MODE_LOWPRIO);
  assign claim     = lowPrio && addressed && localFocus && !csumBad;

  always_comb begin
    busDrive = SYM_NONE;
    if (ctl.statusCyc) begin
      if (csumBad)    busDrive = SYM_ERR;
      else if (claim) busDrive = SYM_FOCUS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid    <= 1'b0;
      csumErr     <= 1'b0;
      focusAccept <= 1'b0;
      extendReq   <= 1'b0;
      vector      <= '0;
      delivMode   <= '0;
      trigMode    <= 1'b0;
      level       <= 1'b0;
      destMode    <= 1'b0;
    end else if (ctl.statusCyc) begin
      msgValid    <= !csumBad && addressed && (!lowPrio || claim);
      csumErr     <= csumBad;
      focusAccept <= claim;
      extendReq   <= !csumBad && addressed && lowPrio && (busIn == SYM_NONE);
      vector      <= vecR;
      delivMode   <= modeR;
      trigMode    <= trigR;
      level       <= lvlR;
      destMode    <= dmR;
    end else begin
      msgValid    <= 1'b0;
      csumErr     <= 1'b0;
      focusAccept <= 1'b0;
      extendReq   <= 1'b0;
    end
  end

  AST_DRIVE_IN_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive != SYM_NONE) |-> ctl.statusCyc); // R7
  AST_VALID_NOT_BAD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !csumErr); // R3
  AST_FOCUS_DELIVERS: assert property (@(posedge clk) disable iff (!rstN)
    focusAccept |-> msgValid); // R8
  AST_EXTEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    extendReq |-> (!msgValid && !focusAccept)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> !msgValid); // R2
endmodule

// File: rtl/irq_msg_rx.sv
module irq_msg_rx
  import irx_pkg::*;
#(
  parameter int SHORT_LEN = 21,
  parameter int LONG_LEN  = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  busIn,
  output logic [SYM_W-1:0]  busDrive,
  input  logic [PHYS_W-1:0] physId,
  input  logic [DEST_W-1:0] logId,
  input  logic              localFocus,
  output logic              msgValid,
  output logic              csumErr,
  output logic              focusAccept,
  output logic              extendReq,
  output logic [VEC_W-1:0]  vector,
  output logic [MODE_W-1:0] delivMode,
  output logic              trigMode,
  output logic              level,
  output logic              destMode
);
  ctl_t ctl;
  logic lowPrio;

  irx_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .busIn(busIn), .lowPrio(lowPrio), .ctl(ctl)
  );

  irx_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busIn(busIn),
    .physId(physId), .logId(logId), .localFocus(localFocus),
    .lowPrio(lowPrio), .busDrive(busDrive),
    .msgValid(msgValid), .csumErr(csumErr), .focusAccept(focusAccept),
    .extendReq(extendReq), .vector(vector), .delivMode(delivMode),
    .trigMode(trigMode), .level(level), .destMode(destMode)
  );
endmodule

// File: tb/sim_irq_msg_rx.sv
module sim_irq_msg_rx;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] tbSym;
  logic [1:0] busIn;
  logic [1:0] busDrive;
  logic [3:0] physId;
  logic [7:0] logId;
  logic       localFocus;
  logic       msgValid, csumErr, focusAccept, extendReq;
  logic [7:0] vector;
  logic [2:0] delivMode;
  logic       trigMode, level, destMode;

  always #10 clk = ~clk;   // 50 MHz

  assign busIn = tbSym | busDrive;   // wired-OR bus

  irq_msg_rx u0 (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busDrive(busDrive),
    .physId(physId), .logId(logId), .localFocus(localFocus),
    .msgValid(msgValid), .csumErr(csumErr), .focusAccept(focusAccept),
    .extendReq(extendReq), .vector(vector), .delivMode(delivMode),
    .trigMode(trigMode), .level(level), .destMode(destMode)
  );

  typedef struct {
    logic [7:0] vec;
    logic [2:0] mode;
    logic       trig, lvl, dm;
    logic       valid, focus, ext, cerr;
    logic [1:0] drv;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  logic statusFlag = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic putSym(logic [1:0] s);
    @(negedge clk);
    tbSym = s;
  endtask

  task automatic sendFrame(string tag, logic dm, logic [2:0] mode, logic lvl, logic trig,
                           logic [7:0] vec, logic [7:0] dest, logic [1:0] delta,
                           logic focus, logic [1:0] other, logic [1:0] tailSym);
    logic [1:0] syms [1:21];
    logic [1:0] sum;
    logic [3:0] arb;
    logic bad, addr, lp, weF, extend;
    logic [1:0] drv, obs;
    exp_t e;
    arb = 4'h6;
    syms[1] = 2'b01;
    for (int i = 0; i < 4; i++) syms[2+i] = {arb[3-i], 1'b0};
    syms[6] = {dm, mode[2]};
    syms[7] = mode[1:0];
    syms[8] = {lvl, trig};
    for (int k = 0; k < 4; k++) begin
      syms[9+k]  = vec[7-2*k -: 2];
      syms[13+k] = dest[7-2*k -: 2];
    end
    sum = 2'b00;
    for (int c = 6; c <= 16; c++) sum = sum + syms[c];
    syms[17] = sum + delta;
    syms[18] = 2'b00;
    syms[19] = other;
    syms[20] = 2'b00;
    syms[21] = 2'b00;

    bad  = (delta != 2'b00);
    addr = dm ? ((dest & logId) != 8'h00)
              : ((dest[3:0] == physId) || (dest[3:0] == 4'hF));
    lp   = (mode == 3'b001);
    weF  = lp && addr && focus && !bad;
    drv  = bad ? 2'b01 : (weF ? 2'b10 : 2'b00);
    obs  = drv | other;
    extend = lp && (obs == 2'b00);

    e.vec = vec; e.mode = mode; e.trig = trig; e.lvl = lvl; e.dm = dm;
    e.valid = !bad && addr && (!lp || weF);
    e.focus = weF;
    e.ext   = !bad && addr && lp && (obs == 2'b00);
    e.cerr  = bad;
    e.drv   = drv;
    e.tag   = tag;
    expQ.push_back(e);

    localFocus = focus;
    for (int c = 1; c <= 21; c++) begin
      putSym(syms[c]);
      statusFlag = (c == 19);
    end
    if (extend) begin
      for (int c = 22; c <= 34; c++) begin
        putSym(tailSym);
        statusFlag = 1'b0;
      end
    end
  endtask

  // monitor: pops an expected item at each status cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (statusFlag) begin
        if (expQ.size() == 0) begin
          chk("R2", "unexpected status cycle", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(e.tag, "busDrive in cycle 19", int'(busDrive), int'(e.drv));
          @(negedge clk);
          #3;
          chk(e.tag, "msgValid", int'(msgValid), int'(e.valid));
          chk(e.tag, "focusAccept", int'(focusAccept), int'(e.focus));
          chk(e.tag, "extendReq", int'(extendReq), int'(e.ext));
          chk(e.tag, "csumErr", int'(csumErr), int'(e.cerr));
          chk("R2", "vector", int'(vector), int'(e.vec));
          chk("R2", "delivMode", int'(delivMode), int'(e.mode));
          chk("R2", "trig/level/destMode", int'({trigMode, level, destMode}),
              int'({e.trig, e.lvl, e.dm}));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    tbSym = 2'b00;
    physId = 4'h5;
    logId = 8'h10;
    localFocus = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk("R12", "pulses in reset", int'({msgValid, csumErr, focusAccept, extendReq}), 0);
    chk("R12", "fields in reset", int'({vector, delivMode, trigMode, level, destMode}), 0);
    chk("R12", "busDrive in reset", int'(busDrive), 0);
    rstN = 1'b1;

    // R1: idle symbols other than 01 are ignored
    foreach (expQ[i]) ;
    for (int g = 0; g < 4; g++) begin
      putSym((g == 2) ? 2'b00 : ((g % 2 == 0) ? 2'b10 : 2'b11));
      #3;
      chk("R1", "busDrive on idle symbol", int'(busDrive), 0);
      chk("R1", "msgValid on idle symbol", int'(msgValid), 0);
    end

    //        tag    dm  mode    lvl  trg  vec    dest   dlt  foc  other  tail
    sendFrame("R1",  0, 3'b000, 1, 0, 8'h3C, 8'h05, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R4",  0, 3'b000, 0, 1, 8'hA7, 8'hA5, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R5",  0, 3'b010, 1, 1, 8'h41, 8'h3F, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R7",  0, 3'b000, 0, 0, 8'h99, 8'h56, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R6",  1, 3'b000, 1, 0, 8'h52, 8'h30, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R6",  1, 3'b100, 0, 1, 8'hE1, 8'h0C, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R3",  0, 3'b000, 1, 0, 8'h77, 8'h05, 2'd1, 0, 2'b00, 2'b00);
    sendFrame("R3",  1, 3'b001, 0, 0, 8'h12, 8'h10, 2'd3, 1, 2'b00, 2'b00);
    sendFrame("R8",  0, 3'b001, 1, 1, 8'hC4, 8'h05, 2'd0, 1, 2'b00, 2'b00);
    sendFrame("R9",  1, 3'b001, 0, 1, 8'h6E, 8'h90, 2'd0, 0, 2'b00, 2'b01);
    sendFrame("R11", 0, 3'b000, 1, 1, 8'hFF, 8'h05, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R10", 0, 3'b001, 0, 0, 8'h2B, 8'h0F, 2'd0, 0, 2'b10, 2'b00);
    sendFrame("R11", 1, 3'b000, 0, 1, 8'h01, 8'hFF, 2'd0, 0, 2'b00, 2'b00);
    sendFrame("R9",  0, 3'b001, 1, 0, 8'h80, 8'h75, 2'd0, 0, 2'b00, 2'b01);
    sendFrame("R9",  0, 3'b000, 0, 0, 8'h5A, 8'h05, 2'd0, 0, 2'b00, 2'b00);

    repeat (4) putSym(2'b00);
    #3;
    chk("R2", "expected queue drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule